// File: doc/BRIEF.md
# Dual-Port Sample Deinterleaver and Formatter

This block takes two sample ports, A and B, and places their contents on two output paths according to a 2-bit routing mode. Mode 00 passes each port to its own path. Modes 01 and 10 take one port that carries alternating A and B samples and split it into an aligned pair, one sample on each path. Mode 11 takes half-rate samples from both ports and merges them into one stream on path A. In the split modes a marker decides which sample is the A sample. The marker is either a rising edge on a transmit-enable input or the MSB of the port that carries no data.

Every sample is normalised to two's complement before it is routed. A format control input selects two's complement input or offset-binary input. Offset-binary samples have their top bit inverted. Outputs are registered, and each path has its own valid strobe. The block runs on a single clock with a synchronous active-high reset.

Top module: `dual_port_sample_router`

## Requirements
- R1: During and after reset both output data buses are zero and both valid strobes are low until the first emission.
- R2: With `twos_fmt`=1 a sample is routed unchanged. With `twos_fmt`=0 the sample is offset binary and is routed with its top bit inverted (bit 15 for the default 16-bit width).
- R3: In mode 00, a valid input puts port A on `out_a` and port B on `out_b` at the next clock edge, with both valid strobes high for one cycle.
- R4: Mode 01 splits the interleaved stream on port A, and mode 10 splits the stream on port B. When a B sample is received while an A sample is held, the next edge emits the held A on `out_a` and the B on `out_b`, with both strobes high for one cycle, once per pair.
- R5: With `marker_sel`=0, a valid sample is an A sample when `tx_en` is 1 and `tx_en` was 0 on the previous valid sample since the last phase clear. After a phase clear the previous value counts as 0.
- R6: With `marker_sel`=1, the raw MSB of the idle port marks the sample: 1 means A, 0 means B. The idle port is port B in mode 01 and port A in mode 10.
- R7: In the split modes, a B sample received while no A sample is held is discarded and produces no output. A new A sample replaces an A sample that is already held.
- R8: In mode 11, a valid input puts port A on `out_a` at the next edge and port B on `out_a` at the edge after that, with `out_a_valid` high for both cycles. `out_b_valid` stays low.
- R9: In mode 11, a valid input that arrives in the cycle where the stored port B sample is being emitted is ignored.
- R10: A change of `mode` clears the pairing phase: the held A sample, the pending merge sample and the `tx_en` history. An input in that same cycle is handled under the new mode.
- R11: `out_b_valid` is never high without `out_a_valid`. While a valid strobe is low, its data bus keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Routing mode: 00 pass, 01 split A, 10 split B, 11 merge |
| twos_fmt | input | 1 | 1: input is two's complement, 0: input is offset binary |
| marker_sel | input | 1 | A/B marker source: 0 transmit-enable edge, 1 idle-port MSB |
| in_valid | input | 1 | Input samples valid this cycle |
| port_a | input | 16 | Input sample port A |
| port_b | input | 16 | Input sample port B |
| tx_en | input | 1 | Transmit-enable marker |
| out_a | output | 16 | Path A data, two's complement |
| out_a_valid | output | 1 | Path A data valid |
| out_b | output | 16 | Path B data, two's complement |
| out_b_valid | output | 1 | Path B data valid |

## Verification
A mode change can fall in the same cycle as state left over from the previous mode: a merge sample waiting to be emitted, or a split A sample held for pairing. The bench starts a merge, then switches to mode 00 with a valid input in the very next cycle. It expects the pass-through pair rather than the stale port B sample, and it expects no later emission of that sample. It also holds an A sample in split mode, switches away and back, and sends a B sample first. That B sample must be discarded, which shows that the held A was cleared.

// File: rtl/sr_pkg.sv
package sr_pkg;
    typedef enum logic [1:0] {
        MODE_PASS    = 2'b00,
        MODE_SPLIT_A = 2'b01,
        MODE_SPLIT_B = 2'b10,
        MODE_MERGE   = 2'b11
    } route_mode_e;

    typedef struct packed {
        logic [1:0]  mode;
        logic        have_a;
        logic        pend;
        logic        tx_prev;
        logic [15:0] held;
        logic [15:0] oa;
        logic [15:0] ob;
        logic        va;
        logic        vb;
    } router_state_t;
endpackage

// File: rtl/sr_fmt_norm.sv
module sr_fmt_norm #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         twos_fmt,
    output logic [W-1:0] norm
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        norm = twos_fmt ? raw : (raw ^ TOP_BIT);
    end
endmodule

// File: rtl/sr_phase_detect.sv
module sr_phase_detect (
    input  logic marker_sel,
    input  logic tx_en,
    input  logic tx_prev,
    input  logic idle_msb,
    output logic is_a
);
    always_comb begin
        if (marker_sel) is_a = idle_msb;
        else            is_a = tx_en & ~tx_prev;
    end
endmodule

// File: rtl/dual_port_sample_router.sv
module dual_port_sample_router
    import sr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic         twos_fmt,
    input  logic         marker_sel,
    input  logic         in_valid,
    input  logic [W-1:0] port_a,
    input  logic [W-1:0] port_b,
    input  logic         tx_en,
    output logic [W-1:0] out_a,
    output logic         out_a_valid,
    output logic [W-1:0] out_b,
    output logic         out_b_valid
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [1:0]   mode;
        logic         have_a;
        logic         pend;
        logic         tx_prev;
        logic [W-1:0] held;
        logic [W-1:0] oa;
        logic [W-1:0] ob;
        logic         va;
        logic         vb;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] norm_a, norm_b, split_src;
    logic         idle_msb, is_a, changed;

    sr_fmt_norm #(.W(W)) u_norm_a (.raw(port_a), .twos_fmt(twos_fmt), .norm(norm_a));
    sr_fmt_norm #(.W(W)) u_norm_b (.raw(port_b), .twos_fmt(twos_fmt), .norm(norm_b));

    always_comb begin
        changed   = (mode != st_q.mode);
        split_src = (mode == MODE_SPLIT_B) ? norm_b : norm_a;
        idle_msb  = (mode == MODE_SPLIT_B) ? port_a[MSB] : port_b[MSB];
    end

    sr_phase_detect u_phase (
        .marker_sel(marker_sel),
        .tx_en     (tx_en),
        .tx_prev   (changed ? 1'b0 : st_q.tx_prev),
        .idle_msb  (idle_msb),
        .is_a      (is_a)
    );

    always_comb begin
        st_d         = st_q;
        st_d.mode    = mode;
        st_d.va      = 1'b0;
        st_d.vb      = 1'b0;
        st_d.pend    = 1'b0;
        st_d.have_a  = changed ? 1'b0 : st_q.have_a;
        st_d.tx_prev = changed ? 1'b0 : st_q.tx_prev;
        unique case (route_mode_e'(mode))
            MODE_PASS: begin
                if (in_valid) begin
                    st_d.oa = norm_a;
                    st_d.ob = norm_b;
                    st_d.va = 1'b1;
                    st_d.vb = 1'b1;
                end
            end
            MODE_SPLIT_A, MODE_SPLIT_B: begin
                if (in_valid) begin
                    st_d.tx_prev = tx_en;
                    if (is_a) begin
                        st_d.held   = split_src;
                        st_d.have_a = 1'b1;
                    end else if (st_d.have_a) begin
                        st_d.oa     = st_q.held;
                        st_d.ob     = split_src;
                        st_d.va     = 1'b1;
                        st_d.vb     = 1'b1;
                        st_d.have_a = 1'b0;
                    end
                end
            end
            MODE_MERGE: begin
                if (st_q.pend && !changed) begin
                    st_d.oa = st_q.held;
                    st_d.va = 1'b1;
                end else if (in_valid) begin
                    st_d.oa   = norm_a;
                    st_d.held = norm_b;
                    st_d.pend = 1'b1;
                    st_d.va   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_a       = st_q.oa;
    assign out_b       = st_q.ob;
    assign out_a_valid = st_q.va;
    assign out_b_valid = st_q.vb;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_a_valid && !out_b_valid));

    // R11
    b_needs_a_chk: assert property (@(posedge clk) disable iff (rst)
        out_b_valid |-> out_a_valid);

    // R11
    hold_a_chk: assert property (@(posedge clk) disable iff (rst)
        !out_a_valid |-> $stable(out_a));

    // R11
    hold_b_chk: assert property (@(posedge clk) disable iff (rst)
        !out_b_valid |-> $stable(out_b));

    // R8
    merge_second_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && mode == 2'b11) |=> (out_a_valid && !out_b_valid));

    // R3
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_a_valid |-> ($past(in_valid) || $past(st_q.pend)));
endmodule

// File: tb/dual_port_sample_router_test.sv
module dual_port_sample_router_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic        twos_fmt, marker_sel, in_valid, tx_en;
    logic [15:0] port_a, port_b;
    logic [15:0] out_a, out_b;
    logic        out_a_valid, out_b_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_port_sample_router uut (
        .clk(clk), .rst(rst), .mode(mode), .twos_fmt(twos_fmt),
        .marker_sel(marker_sel), .in_valid(in_valid),
        .port_a(port_a), .port_b(port_b), .tx_en(tx_en),
        .out_a(out_a), .out_a_valid(out_a_valid),
        .out_b(out_b), .out_b_valid(out_b_valid)
    );

    function automatic logic [15:0] cv(input logic [15:0] x, input logic tw);
        return tw ? x : 16'(x + 16'h8000);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic v,
                        input logic [15:0] a, input logic [15:0] b, input logic tx);
        mode = m; in_valid = v; port_a = a; port_b = b; tx_en = tx;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_valids(input string req, input logic ea, input logic eb);
        chk(req, {14'd0, out_a_valid, out_b_valid}, {14'd0, ea, eb});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 2'b00; twos_fmt = 1'b1; marker_sel = 1'b0;
        in_valid = 1'b0; port_a = 16'h1234; port_b = 16'h5678; tx_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_valids("R1 valids in reset", 1'b0, 1'b0);
        chk("R1 out_a in reset", out_a, 16'h0000);
        chk("R1 out_b in reset", out_b, 16'h0000);
        rst = 1'b0;
        step(2'b00, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0);
        chk_valids("R1 idle after reset", 1'b0, 1'b0);
        chk("R1 out_a zero after reset", out_a, 16'h0000);

        // R3 / R2 pass-through sweep, both formats
        for (int t = 0; t < 2; t++) begin
            twos_fmt = t[0];
            for (int i = 0; i < 256; i++) begin
                logic [15:0] a, b;
                a = 16'(i * 257);
                b = 16'(~(i * 131));
                step(2'b00, 1'b1, a, b, 1'b0);
                chk_valids("R3 pass valids", 1'b1, 1'b1);
                chk("R2 R3 pass out_a", out_a, cv(a, t[0]));
                chk("R2 R3 pass out_b", out_b, cv(b, t[0]));
            end
        end
        step(2'b00, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_valids("R11 idle pass", 1'b0, 1'b0);
        chk("R11 out_a held", out_a, cv(16'(~(255 * 131)) == 16'h0 ? 16'h0 : 16'(255 * 257), 1'b1));

        // R4 R5 split from port A, transmit-enable marker, offset binary (R2)
        twos_fmt = 1'b0; marker_sel = 1'b0;
        for (int k = 0; k < 64; k++) begin
            logic [15:0] sa, sb;
            sa = 16'(k * 1021);
            sb = 16'(k * 77 + 5);
            step(2'b01, 1'b1, sa, 16'h0, 1'b1);
            chk_valids("R5 A sample no output", 1'b0, 1'b0);
            step(2'b01, 1'b1, sb, 16'h0, 1'b0);
            chk_valids("R4 pair valids", 1'b1, 1'b1);
            chk("R4 R2 split A path", out_a, cv(sa, 1'b0));
            chk("R4 R2 split B path", out_b, cv(sb, 1'b0));
        end
        // R5 tx held high: second sample is not an edge, so it is B
        twos_fmt = 1'b1;
        step(2'b01, 1'b1, 16'h1111, 16'h0, 1'b1);
        step(2'b01, 1'b1, 16'h2222, 16'h0, 1'b1);
        chk_valids("R5 level is not edge", 1'b1, 1'b1);
        chk("R5 A from edge", out_a, 16'h1111);
        chk("R5 B without edge", out_b, 16'h2222);

        // R4 R6 split from port B, idle-port MSB marker (port A idle)
        marker_sel = 1'b1;
        for (int k = 0; k < 64; k++) begin
            logic [15:0] sa, sb;
            sa = 16'(k * 4093 + 3);
            sb = 16'(k * 999);
            step(2'b10, 1'b1, 16'h8000, sa, 1'b0);
            chk_valids("R6 MSB=1 is A", 1'b0, 1'b0);
            step(2'b10, 1'b1, 16'h7FFF, sb, 1'b1);
            chk_valids("R6 pair valids", 1'b1, 1'b1);
            chk("R4 R6 split-B A path", out_a, sa);
            chk("R4 R6 split-B B path", out_b, sb);
        end

        // R7 B with no held A discarded; second A replaces first
        step(2'b10, 1'b1, 16'h0000, 16'hAAAA, 1'b0);
        chk_valids("R7 orphan B dropped", 1'b0, 1'b0);
        step(2'b10, 1'b1, 16'h8000, 16'h0101, 1'b0);
        step(2'b10, 1'b1, 16'h8000, 16'h0202, 1'b0);
        chk_valids("R7 second A no output", 1'b0, 1'b0);
        step(2'b10, 1'b1, 16'h0000, 16'h0303, 1'b0);
        chk("R7 newer A kept", out_a, 16'h0202);
        chk("R7 B paired", out_b, 16'h0303);

        // R8 merge
        for (int k = 0; k < 64; k++) begin
            logic [15:0] a, b;
            a = 16'(k * 3001);
            b = 16'(k * 503 + 9);
            step(2'b11, 1'b1, a, b, 1'b0);
            chk_valids("R8 first merge valids", 1'b1, 1'b0);
            chk("R8 merge first is A", out_a, a);
            step(2'b11, 1'b0, 16'h0, 16'h0, 1'b0);
            chk_valids("R8 second merge valids", 1'b1, 1'b0);
            chk("R8 merge second is B", out_a, b);
        end
        // R9 input during B emission ignored
        step(2'b11, 1'b1, 16'h1357, 16'h2468, 1'b0);
        step(2'b11, 1'b1, 16'hDEAD, 16'hBEEF, 1'b0);
        chk("R9 B emitted", out_a, 16'h2468);
        step(2'b11, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_valids("R9 ignored input gives nothing", 1'b0, 1'b0);
        chk("R9 R11 out_a held", out_a, 16'h2468);

        // R10 mode change in the cycle a merge B is pending
        step(2'b11, 1'b1, 16'h0A0A, 16'h0B0B, 1'b0);
        step(2'b00, 1'b1, 16'h1C1C, 16'h1D1D, 1'b0);
        chk_valids("R10 pass after merge", 1'b1, 1'b1);
        chk("R10 no stale B on out_a", out_a, 16'h1C1C);
        chk("R10 pass out_b", out_b, 16'h1D1D);
        step(2'b11, 1'b0, 16'h0, 16'h0, 1'b0);
        chk_valids("R10 pending dropped", 1'b0, 1'b0);

        // R10 held A cleared by mode change
        marker_sel = 1'b0;
        step(2'b01, 1'b1, 16'h4444, 16'h0, 1'b1);
        step(2'b00, 1'b0, 16'h0, 16'h0, 1'b0);
        step(2'b01, 1'b1, 16'h5555, 16'h0, 1'b0);
        chk_valids("R10 held A cleared", 1'b0, 1'b0);
        // R10 tx history cleared: tx high on first sample counts as edge
        step(2'b10, 1'b1, 16'h0, 16'h6666, 1'b1);
        step(2'b10, 1'b1, 16'h0, 16'h7777, 1'b0);
        chk_valids("R10 R5 fresh edge", 1'b1, 1'b1);
        chk("R10 R5 A after clear", out_a, 16'h6666);
        chk("R10 R5 B after clear", out_b, 16'h7777);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule